// File: doc/BRIEF.md
# Timer/Event Counter with Divided Overflow Output

This block is an 8-bit up-counter that software programs through a small register port. A two-bit mode field picks what advances the counter: rising edges of an external input, a tick derived from the system clock through a power-of-two prescaler, or that same tick gated by the external input being high, which measures how long a pulse lasts. The counter can be halted.

When the counter steps past its top value it takes the value of a preload register in the same clock edge. It also raises an interrupt request that stays high until software clears it, and flips a square-wave output, so that output runs at half the overflow rate. The square wave can drive a buzzer or serve as a programmable clock.

The external input is asynchronous and passes through a two-flop synchronizer before any use. Reads on the register port are combinational. Writes take effect on the next rising clock edge.

Top module: `evt_timer`

## Requirements
- R1: After reset the control, preload and count registers read 0x00, and `irq_req` and `pfd_out` are low.
- R2: With mode 00 (control bits 7:6) the count does not change, whatever `ext_in` does.
- R3: With mode 10 the count advances once every 2^S clocks, where S is control bits 2:0. Writing the control register restarts the prescaler. After a control write on clock edge E0, the count at edge E0+N has risen by floor(N / 2^S).
- R4: With mode 01 each rising edge of `ext_in` advances the count by exactly one, regardless of S. A level held high advances it only once.
- R5: With mode 11 the count advances on each prescaler tick (period 2^S clocks) for as long as the synchronized `ext_in` is high, and it stops while `ext_in` is low.
- R6: An advance from 0xFF loads the count with the preload value on that same edge; the count never shows 0x00 as a wrap value.
- R7: Each overflow sets the interrupt flag (status bit 0, shown on `irq_req`). The flag stays set until a write to the status register with bit 0 = 0. A status write with bit 0 = 1 has no effect.
- R8: `pfd_out` (also status bit 1) toggles on every overflow and holds its level otherwise.
- R9: When an overflow and a flag-clearing status write fall on the same edge, the flag ends up set.
- R10: Register map on `reg_addr`: 0 control (mode in bits 7:6, prescaler select in bits 2:0, bits 5:3 stored and read back), 1 preload, 2 count, 3 status. Each register reads back through `reg_rdata` without delay.
- R11: A write to the count register takes priority over an advance on the same edge. It cancels that advance and any overflow it would have caused: no reload, no flag, no toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_in | input | 1 | External event or pulse input, asynchronous |
| irq_req | output | 1 | Interrupt request flag |
| pfd_out | output | 1 | Square wave at half the overflow rate |

## Verification
Two functions can land on the same edge: an overflow, and a software write that touches the same state. This is either a status write that clears the flag or a count write while the counter sits at 0xFF. The bench creates both cases by loading 0xFE while the counter is halted and starting the timer at divide-by-one. The second clock edge after that start is then the overflow edge, and the bench times its register write to land there. The bench then checks that the flag stays set after the clear attempt. In the other case it checks that the written count wins, and that neither the flag nor the square wave moves.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [1:0] {
    MODE_HALT  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL    = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_PRELOAD = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_COUNT   = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS  = 2'd3;

  // low-bit mask for a divide by 2**sel: a tick fires when these bits are all ones
  function automatic logic [15:0] div_mask(input int unsigned sel);
    return (16'd1 << sel) - 16'd1;
  endfunction

  // value after one advance step, wrapping to the reload value
  function automatic logic [15:0] step_value(input logic [15:0] cur,
                                             input logic [15:0] top,
                                             input logic [15:0] reload);
    return (cur == top) ? reload : cur + 16'd1;
  endfunction

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);

  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], din};
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler
  import evt_timer_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  assign mask = DIV_W'(div_mask(int'(sel)));
  assign tick = ((div_q & mask) == mask);

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] stepped;

  assign stepped = CNT_W'(step_value(16'(cnt_q), 16'(TOP), 16'(preload)));
  assign ovf     = adv & ~ld_en & (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (ld_en) cnt_q <= ld_val;
    else if (adv)   cnt_q <= stepped;
  end

  assign count = cnt_q;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_wr,
  input  logic [CNT_W-1:0]      reg_wdata,
  output logic [CNT_W-1:0]      reg_rdata,
  input  logic                  ext_in,
  output logic                  irq_req,
  output logic                  pfd_out
);

  localparam int MODE_LSB = CNT_W - 2;

  logic [CNT_W-1:0] ctrl_q;
  logic [CNT_W-1:0] preload_q;
  logic             flag_q;
  logic             pfd_q;
  tmr_mode_e        mode;
  logic [SEL_W-1:0] sel;

  // named internal events
  logic ctrl_wr_evt;
  logic pre_wr_evt;
  logic cnt_ld_evt;
  logic flag_clr_evt;
  logic ext_level;
  logic ext_rise;
  logic pre_tick;
  logic adv_evt;
  logic ovf_evt;
  logic [CNT_W-1:0] count;

  assign ctrl_wr_evt  = reg_wr && (reg_addr == ADDR_CTRL);
  assign pre_wr_evt   = reg_wr && (reg_addr == ADDR_PRELOAD);
  assign cnt_ld_evt   = reg_wr && (reg_addr == ADDR_COUNT);
  assign flag_clr_evt = reg_wr && (reg_addr == ADDR_STATUS) && !reg_wdata[0];

  assign mode = tmr_mode_e'(ctrl_q[MODE_LSB +: 2]);
  assign sel  = ctrl_q[SEL_W-1:0];

  evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ext_in),
    .level (ext_level),
    .rise  (ext_rise)
  );

  evt_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ctrl_wr_evt),
    .sel     (sel),
    .tick    (pre_tick)
  );

  always_comb begin
    unique case (mode)
      MODE_EVENT: adv_evt = ext_rise;
      MODE_TIMER: adv_evt = pre_tick;
      MODE_PULSE: adv_evt = pre_tick & ext_level;
      default:    adv_evt = 1'b0;
    endcase
  end

  evt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv_evt),
    .ld_en   (cnt_ld_evt),
    .ld_val  (reg_wdata),
    .preload (preload_q),
    .count   (count),
    .ovf     (ovf_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      preload_q <= '0;
    end else begin
      if (ctrl_wr_evt) ctrl_q    <= reg_wdata;
      if (pre_wr_evt)  preload_q <= reg_wdata;
    end
  end

  // overflow set has priority over a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            flag_q <= 1'b0;
    else if (ovf_evt)      flag_q <= 1'b1;
    else if (flag_clr_evt) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pfd_q <= 1'b0;
    else if (ovf_evt) pfd_q <= ~pfd_q;
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL:    reg_rdata = ctrl_q;
      ADDR_PRELOAD: reg_rdata = preload_q;
      ADDR_COUNT:   reg_rdata = count;
      default:      reg_rdata = {{(CNT_W-2){1'b0}}, pfd_q, flag_q};
    endcase
  end

  assign irq_req = flag_q;
  assign pfd_out = pfd_q;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             cnt_ld,
  input logic [CNT_W-1:0] ld_val,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] preload,
  input logic             adv,
  input logic             ovf,
  input logic             ext_rise,
  input logic             flag_clr,
  input logic             irq_req,
  input logic             pfd_out
);

  assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !cnt_ld) |=> $stable(count));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ovf && !cnt_ld) |=> (count == CNT_W'($past(count) + 1'b1)));

  assert_event_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !ext_rise && !cnt_ld) |=> $stable(count));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (count == $past(preload)));

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> irq_req);

  assert_pfd_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (pfd_out != $past(pfd_out)));

  assert_pfd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> $stable(pfd_out));

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ovf) |=> !irq_req);

  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> (count == $past(ld_val)));

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_evt_timer_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (ctrl_q[CNT_W-1 -: 2]),
  .cnt_ld   (cnt_ld_evt),
  .ld_val   (reg_wdata),
  .count    (count),
  .preload  (preload_q),
  .adv      (adv_evt),
  .ovf      (ovf_evt),
  .ext_rise (ext_rise),
  .flag_clr (flag_clr_evt),
  .irq_req  (irq_req),
  .pfd_out  (pfd_out)
);

// File: tb/test_evt_timer.sv
`timescale 1ns/1ps
module test_evt_timer;

  localparam logic [1:0] A_CTRL = 2'd0, A_PRE = 2'd1, A_CNT = 2'd2, A_STAT = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ext_in = 1'b0;
  logic       irq_req;
  logic       pfd_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_timer i_evt_timer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_in(ext_in),
    .irq_req(irq_req), .pfd_out(pfd_out)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    reg_read(a, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic test_reset;
    expect_reg(A_CTRL, 8'h00, "R1 ctrl");
    expect_reg(A_PRE,  8'h00, "R1 preload");
    expect_reg(A_CNT,  8'h00, "R1 count");
    check(irq_req == 1'b0, "R1 irq", 8'(irq_req), 8'h00);
    check(pfd_out == 1'b0, "R1 pfd", 8'(pfd_out), 8'h00);
  endtask

  task automatic test_regmap;
    reg_write(A_CTRL, 8'h3A);   // mode 00 keeps the counter halted
    expect_reg(A_CTRL, 8'h3A, "R10 ctrl readback");
    reg_write(A_PRE, 8'h5C);
    expect_reg(A_PRE, 8'h5C, "R10 preload readback");
    reg_write(A_CNT, 8'hA3);
    expect_reg(A_CNT, 8'hA3, "R10 count readback");
    expect_reg(A_STAT, 8'h00, "R10 status readback");
    reg_write(A_CTRL, 8'h00);
  endtask

  task automatic test_halt;
    reg_write(A_CNT, 8'h33);
    for (int i = 0; i < 4; i++) begin
      ext_in = 1'b1; wait_cyc(3);
      ext_in = 1'b0; wait_cyc(3);
    end
    expect_reg(A_CNT, 8'h33, "R2 halted count");
  endtask

  task automatic test_timer(input int s, input int n);
    logic [7:0] exp;
    reg_write(A_CNT, 8'h10);
    reg_write(A_CTRL, 8'h80 | 8'(s));
    wait_cyc(n);
    exp = 8'(8'h10 + (n >> s));
    expect_reg(A_CNT, exp, "R3 timer count");
    reg_write(A_CTRL, 8'h00);
  endtask

  task automatic test_event;
    logic [7:0] v;
    reg_write(A_CNT, 8'h00);
    reg_write(A_CTRL, 8'h47);   // event mode, select 7 ignored
    for (int i = 0; i < 5; i++) begin
      ext_in = 1'b1; wait_cyc(3);
      ext_in = 1'b0; wait_cyc(3);
    end
    wait_cyc(4);
    expect_reg(A_CNT, 8'h05, "R4 event edges");
    ext_in = 1'b1; wait_cyc(20);
    reg_read(A_CNT, v);
    check(v == 8'h06, "R4 held level", v, 8'h06);
    ext_in = 1'b0; wait_cyc(4);
    expect_reg(A_CNT, 8'h06, "R4 after release");
    reg_write(A_CTRL, 8'h00);
  endtask

  task automatic test_pulse;
    reg_write(A_CNT, 8'h00);
    reg_write(A_CTRL, 8'hC0);
    wait_cyc(3);
    expect_reg(A_CNT, 8'h00, "R5 idle while low");
    ext_in = 1'b1; wait_cyc(9);
    ext_in = 1'b0; wait_cyc(5);
    expect_reg(A_CNT, 8'h09, "R5 width div1");
    reg_write(A_CTRL, 8'hC1);
    ext_in = 1'b1; wait_cyc(12);
    ext_in = 1'b0; wait_cyc(6);
    expect_reg(A_CNT, 8'h0F, "R5 width div2");
    reg_write(A_CTRL, 8'h00);
  endtask

  task automatic test_overflow;
    logic p0;
    reg_write(A_PRE, 8'h80);
    reg_write(A_CNT, 8'hFD);
    reg_write(A_STAT, 8'h00);
    p0 = pfd_out;
    check(irq_req == 1'b0, "R7 flag clear before", 8'(irq_req), 8'h00);
    reg_write(A_CTRL, 8'h80);
    wait_cyc(2);
    expect_reg(A_CNT, 8'hFF, "R6 top value");
    check(irq_req == 1'b0, "R7 no flag before wrap", 8'(irq_req), 8'h00);
    wait_cyc(1);
    expect_reg(A_CNT, 8'h80, "R6 reload");
    check(irq_req == 1'b1, "R7 flag set", 8'(irq_req), 8'h01);
    check(pfd_out == ~p0, "R8 toggle", 8'(pfd_out), 8'(~p0));
    wait_cyc(4);
    check(irq_req == 1'b1, "R7 flag sticky", 8'(irq_req), 8'h01);
    check(pfd_out == ~p0, "R8 hold", 8'(pfd_out), 8'(~p0));
    reg_write(A_STAT, 8'h01);
    check(irq_req == 1'b1, "R7 write one ignored", 8'(irq_req), 8'h01);
    reg_write(A_STAT, 8'h00);
    check(irq_req == 1'b0, "R7 write zero clears", 8'(irq_req), 8'h00);
    reg_write(A_CTRL, 8'h00);
  endtask

  task automatic test_pfd_rate;
    logic p0;
    reg_write(A_PRE, 8'hFE);
    reg_write(A_CNT, 8'hFE);
    p0 = pfd_out;
    reg_write(A_CTRL, 8'h80);
    wait_cyc(2);
    check(pfd_out == ~p0, "R8 first wrap", 8'(pfd_out), 8'(~p0));
    expect_reg(A_CNT, 8'hFE, "R6 reload FE");
    wait_cyc(2);
    check(pfd_out == p0, "R8 second wrap", 8'(pfd_out), 8'(p0));
    reg_write(A_CTRL, 8'h00);
  endtask

  task automatic test_set_wins;
    reg_write(A_PRE, 8'h00);
    reg_write(A_CNT, 8'hFE);
    reg_write(A_STAT, 8'h00);
    check(irq_req == 1'b0, "R9 flag low before", 8'(irq_req), 8'h00);
    reg_write(A_CTRL, 8'h80);      // edge E0
    reg_write(A_STAT, 8'h00);      // lands on E2, the wrap edge
    check(irq_req == 1'b1, "R9 set beats clear", 8'(irq_req), 8'h01);
    reg_write(A_CTRL, 8'h00);
    reg_write(A_STAT, 8'h00);
  endtask

  task automatic test_load_wins;
    logic p0;
    reg_write(A_CNT, 8'h00);
    reg_write(A_CTRL, 8'h80);
    wait_cyc(3);
    reg_write(A_CNT, 8'h40);
    expect_reg(A_CNT, 8'h40, "R11 load over step");
    wait_cyc(3);
    expect_reg(A_CNT, 8'h43, "R11 steps resume");
    reg_write(A_CTRL, 8'h00);
    reg_write(A_PRE, 8'h11);
    reg_write(A_CNT, 8'hFE);
    reg_write(A_STAT, 8'h00);
    p0 = pfd_out;
    reg_write(A_CTRL, 8'h80);      // E0; count FF during E1..E2
    reg_write(A_CNT, 8'h20);       // lands on E2
    expect_reg(A_CNT, 8'h20, "R11 load over wrap");
    check(irq_req == 1'b0, "R11 no flag", 8'(irq_req), 8'h00);
    check(pfd_out == p0, "R11 no toggle", 8'(pfd_out), 8'(p0));
    reg_write(A_CTRL, 8'h00);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0x00 expected 0x01");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    test_reset;
    rst_n = 1'b1;
    wait_cyc(2);
    test_reset;
    test_regmap;
    test_halt;
    test_timer(0, 7);
    test_timer(2, 21);
    test_timer(3, 37);
    test_event;
    test_pulse;
    test_overflow;
    test_pfd_rate;
    test_set_wins;
    test_load_wins;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule